// File: doc/BRIEF.md
# Maskable Header Match Router

This block decides where a received cell goes by looking at its 32-bit header. Four match slots each hold a programmed header value and a bit mask. A header bit is compared only where the mask bit of that slot is 1. A header word arrives with a one-cycle valid strobe. The block checks it against all enabled slots in parallel. One clock later it presents a one-hot output-port select, together with a flag that says whether no slot matched.

Header filtering can be switched off as a whole. When it is off, every cell goes to port 0 and no miss is ever reported. A filter miss sets a sticky status flag, which software clears through a clear input. An interrupt enable gates that flag onto an interrupt output. The configuration registers are plain inputs, driven by a register bank outside this block.

Top module: `hdr_match_router`

## Requirements
- R1: After reset, out_sel is 4'b0000 and out_vld, no_match, miss_flag and irq are all 0.
- R2: Slot i matches when ((hdr_word XOR value_i) AND mask_i) is zero. A header bit whose mask bit is 0 has no effect on the compare, and an all-zero mask matches any header.
- R3: One clock after hdr_vld is sampled high, out_vld is 1 for exactly one cycle. In that cycle out_sel has bit i set for the chosen port i (bit 0 = port 0 ... bit 3 = port 3), and it never has more than one bit set.
- R4: When more than one enabled slot matches, the lowest-numbered slot is chosen.
- R5: A slot whose port_en bit is 0 never matches.
- R6: With the filter enabled and no enabled slot matching, out_sel becomes 4'b0000 and no_match becomes 1.
- R7: With filt_en low, a header goes to port 0 (out_sel = 4'b0001) and no_match is 0, whatever the slot contents.
- R8: miss_flag is set by every miss (R6) and stays set until stat_clr is sampled high. A miss in the same cycle as stat_clr leaves it set.
- R9: irq equals miss_flag AND irq_en.
- R10: Without hdr_vld, out_sel and no_match keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_word | input | 32 | Assembled cell header |
| hdr_vld | input | 1 | Header valid strobe |
| match_val | input | 128 | Four slot values, slot i in bits [32i+31:32i] |
| match_msk | input | 128 | Four slot masks, same layout; 1 = bit compared |
| port_en | input | 4 | Per-slot enable |
| filt_en | input | 1 | Header filter enable |
| irq_en | input | 1 | Interrupt enable for the miss flag |
| stat_clr | input | 1 | Clears the sticky miss flag |
| out_sel | output | 4 | One-hot output port select |
| out_vld | output | 1 | Routing result valid pulse |
| no_match | output | 1 | No slot matched the last header |
| miss_flag | output | 1 | Sticky filter miss status |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked by assertions on every cycle. These are the one-hot shape of out_sel, the strobe-to-result latency, the agreement between an empty select and no_match, the fixed port-0 route while filtering is off, holding between strobes, the miss flag being set by every miss, and the picker never choosing a slot that did not hit. The bench scenarios are needed to show the parts that depend on programmed contents: the masked compare itself, which slot wins among several, port disables, and clearing the sticky flag with and without the interrupt enable.

// File: rtl/hdr_route_pkg.sv
// Package: shared constants for the header match router.
// Assumes: consumers use these as parameter defaults only.
package hdr_route_pkg;
    localparam int DEF_PORTS = 4;
    localparam int DEF_HDR_W = 32;
endpackage

// File: rtl/hdr_cmp_lane.sv
// Module: one masked compare slot.
// Flags a hit when all header bits selected by the mask equal the stored value.
// Assumes: the value and mask are stable while the header is evaluated.
module hdr_cmp_lane #(
    parameter int HDR_W = hdr_route_pkg::DEF_HDR_W
) (
    input  logic [HDR_W-1:0] hdr,
    input  logic [HDR_W-1:0] value,
    input  logic [HDR_W-1:0] mask,
    input  logic             lane_en,
    output logic             hit
);
    logic [HDR_W-1:0] diff;

    // Masked difference; a hit when no compared bit differs and the lane is enabled.
    always_comb begin
        diff = (hdr ^ value) & mask;
        hit  = lane_en && (diff == '0);
    end
endmodule

// File: rtl/hdr_prio_pick.sv
// Module: lowest-index priority picker.
// Turns a hit vector into a one-hot grant of the lowest set bit.
// Assumes: purely combinational, no state.
module hdr_prio_pick #(
    parameter int N = hdr_route_pkg::DEF_PORTS
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    // Scan from the top down so the lowest requesting index is written last.
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) gnt = N'(1) << i;
        end
        any = |req;
    end

    // R4: the grant is never given to an index that does not request
    always_comb begin
        prio_gnt_subset_chk: assert ((gnt & ~req) == '0);
    end
endmodule

// File: rtl/hdr_match_router.sv
// Module: top of the header match router.
// Compares each valid header against masked slots, picks the lowest hit,
// and registers the port select, a miss flag and a sticky status one cycle later.
// Assumes: slot registers are driven from outside and are flat-packed by slot index.
module hdr_match_router #(
    parameter int NUM_PORTS = hdr_route_pkg::DEF_PORTS,
    parameter int HDR_W     = hdr_route_pkg::DEF_HDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [HDR_W-1:0]           hdr_word,
    input  logic                       hdr_vld,
    input  logic [NUM_PORTS*HDR_W-1:0] match_val,
    input  logic [NUM_PORTS*HDR_W-1:0] match_msk,
    input  logic [NUM_PORTS-1:0]       port_en,
    input  logic                       filt_en,
    input  logic                       irq_en,
    input  logic                       stat_clr,
    output logic [NUM_PORTS-1:0]       out_sel,
    output logic                       out_vld,
    output logic                       no_match,
    output logic                       miss_flag,
    output logic                       irq
);
    localparam logic [NUM_PORTS-1:0] PORT0_SEL = NUM_PORTS'(1);

    logic [NUM_PORTS-1:0] hits;
    logic [NUM_PORTS-1:0] pick;
    logic                 pick_any;
    logic [NUM_PORTS-1:0] next_sel;
    logic                 next_miss;

    // One compare lane per slot.
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_lane
        hdr_cmp_lane #(.HDR_W(HDR_W)) u_lane (
            .hdr     (hdr_word),
            .value   (match_val[g*HDR_W +: HDR_W]),
            .mask    (match_msk[g*HDR_W +: HDR_W]),
            .lane_en (port_en[g]),
            .hit     (hits[g])
        );
    end

    hdr_prio_pick #(.N(NUM_PORTS)) u_pick (
        .req (hits),
        .gnt (pick),
        .any (pick_any)
    );

    // Routing decision: bypass to port 0 when filtering is off.
    always_comb begin
        if (filt_en) begin
            next_sel  = pick;
            next_miss = !pick_any;
        end else begin
            next_sel  = PORT0_SEL;
            next_miss = 1'b0;
        end
    end

    // Result registers: capture the decision on each header strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sel  <= '0;
            no_match <= 1'b0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= hdr_vld;
            if (hdr_vld) begin
                out_sel  <= next_sel;
                no_match <= next_miss;
            end
        end
    end

    // Sticky miss status: a new miss wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_flag <= 1'b0;
        end else if (hdr_vld && next_miss) begin
            miss_flag <= 1'b1;
        end else if (stat_clr) begin
            miss_flag <= 1'b0;
        end
    end

    // Interrupt gating of the status flag.
    always_comb irq = miss_flag && irq_en;

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_sel));

    // R3
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_vld |=> out_vld);

    // R6
    miss_empty_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (no_match == (out_sel == '0)));

    // R7
    bypass_port0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_vld && !filt_en) |=> (out_sel == PORT0_SEL && !no_match));

    // R10
    hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_vld |=> ($stable(out_sel) && $stable(no_match)));

    // R8
    miss_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && no_match) |-> miss_flag);
endmodule

// File: tb/hdr_match_router_bench.sv
// Bench: directed scenarios for the header match router; 50 MHz clock.
module hdr_match_router_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [31:0]  hdr_word;
    logic         hdr_vld;
    logic [127:0] match_val;
    logic [127:0] match_msk;
    logic [3:0]   port_en;
    logic         filt_en, irq_en, stat_clr;
    logic [3:0]   out_sel;
    logic         out_vld, no_match, miss_flag, irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hdr_match_router u_hdr_match_router (
        .clk(clk), .rst_n(rst_n), .hdr_word(hdr_word), .hdr_vld(hdr_vld),
        .match_val(match_val), .match_msk(match_msk), .port_en(port_en),
        .filt_en(filt_en), .irq_en(irq_en), .stat_clr(stat_clr),
        .out_sel(out_sel), .out_vld(out_vld), .no_match(no_match),
        .miss_flag(miss_flag), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one header for one cycle; return at the following negedge.
    task automatic send(input logic [31:0] h);
        @(negedge clk);
        hdr_word = h;
        hdr_vld  = 1'b1;
        @(negedge clk);
        hdr_vld  = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 out_sel", 32'(out_sel), 0);
        check("R1 out_vld", 32'(out_vld), 0);
        check("R1 no_match", 32'(no_match), 0);
        check("R1 miss_flag", 32'(miss_flag), 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_exact;
        send(32'h1234_5678);
        check("R3 out_vld", 32'(out_vld), 1);
        check("R3 exact slot2", 32'(out_sel), 32'h4);
        check("R3 no_match", 32'(no_match), 0);
        @(negedge clk);
        check("R3 vld one cycle", 32'(out_vld), 0);
    endtask

    task automatic t_mask_ignore;
        send(32'h77AB_CD77);
        check("R2 masked bits ignored slot1", 32'(out_sel), 32'h2);
    endtask

    task automatic t_priority;
        send(32'h1111_9999);
        check("R4 slot0 beats slot3", 32'(out_sel), 32'h1);
    endtask

    task automatic t_disable;
        port_en = 4'b1110;
        send(32'h1111_0000);
        check("R5 disabled slot0 skipped", 32'(out_sel), 32'h8);
        port_en = 4'b1111;
    endtask

    task automatic t_miss;
        port_en = 4'b0111;
        irq_en  = 1'b1;
        send(32'hFFFF_FFFF);
        check("R6 miss sel", 32'(out_sel), 0);
        check("R6 miss flag", 32'(no_match), 1);
        check("R8 sticky set", 32'(miss_flag), 1);
        check("R9 irq on", 32'(irq), 1);
        port_en = 4'b1111;
    endtask

    task automatic t_hold;
        send(32'h77AB_CD77);
        check("R10 sel", 32'(out_sel), 32'h2);
        hdr_word = 32'hFFFF_FFFF;
        port_en  = 4'b0000;
        repeat (3) @(negedge clk);
        check("R10 sel held", 32'(out_sel), 32'h2);
        check("R10 no_match held", 32'(no_match), 0);
        check("R10 no vld", 32'(out_vld), 0);
        check("R8 flag kept", 32'(miss_flag), 1);
        port_en = 4'b1111;
    endtask

    task automatic t_status;
        irq_en = 1'b0;
        @(negedge clk);
        check("R9 irq masked", 32'(irq), 0);
        irq_en = 1'b1;
        // miss together with clear: set wins
        port_en  = 4'b0000;
        stat_clr = 1'b1;
        send(32'h0);
        check("R8 set beats clear", 32'(miss_flag), 1);
        port_en  = 4'b1111;
        @(negedge clk);
        stat_clr = 1'b0;
        check("R8 cleared", 32'(miss_flag), 0);
        check("R9 irq off", 32'(irq), 0);
    endtask

    task automatic t_bypass;
        filt_en = 1'b0;
        port_en = 4'b0000;
        send(32'hFFFF_FFFF);
        check("R7 bypass port0", 32'(out_sel), 32'h1);
        check("R7 no miss", 32'(no_match), 0);
        check("R7 flag untouched", 32'(miss_flag), 0);
        filt_en = 1'b1;
        port_en = 4'b1111;
    endtask

    initial begin
        rst_n = 1'b0; hdr_word = '0; hdr_vld = 1'b0;
        filt_en = 1'b1; irq_en = 1'b0; stat_clr = 1'b0; port_en = 4'b1111;
        match_val = {32'h0000_0000, 32'h1234_5678, 32'h00AB_CD00, 32'h1111_0000};
        match_msk = {32'h0000_0000, 32'hFFFF_FFFF, 32'h00FF_FF00, 32'hFFFF_0000};
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_exact;
        t_mask_ignore;
        t_priority;
        t_disable;
        t_miss;
        t_hold;
        t_status;
        t_bypass;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule